// File: doc/BRIEF.md
# Supply Undervoltage Reset Generator

This block turns a digital supply-good indication into a power-on and brown-out reset for a small controller. It watches a flag that reports the regulated logic supply is too low. It ignores short dips of that flag. Once a dip is long enough it pulls the reset line low. When the supply comes back it keeps the line low for a fixed stretch. A second flag reports whether the battery rail is high enough for the block to run at all. Without it the reset pad is released to high impedance and is not driven.

The reset pad is modelled as an open-drain enable: `1` means the pad pulls low and `0` means it floats. A busy status accompanies the pad. The surrounding mode controller uses it to refuse any operating-mode change while a reset is asserted or still being stretched. All times are counted in ticks of a slow timebase strobe, so the debounce and stretch lengths are parameters in tick units.

Top module: `uv_reset_gen`

## Requirements
- R1: The pad enable `nres_pull_o` rises only after the synchronised undervoltage flag has been high for `DEB_TICKS` consecutive ticks. A raw pulse of fewer than `DEB_TICKS` cycles, with a tick every cycle, leaves the pad released and `rst_busy_o` low.
- R2: After the undervoltage flag clears, the reset is stretched for `HOLD_TICKS` ticks. With a tick every cycle, the pad enable stays 1 for exactly `HOLD_TICKS + 3` clock cycles after the raw flag falls: two synchroniser cycles, one entry cycle, then the stretch.
- R3: While `rst_ni` is low the pad enable and busy are both 1. With the flag clear, the pad enable stays 1 for `HOLD_TICKS + 3` cycles after `rst_ni` rises.
- R4: While the undervoltage flag stays high and `vs_ok_i` is 1, the pad enable stays 1 for any length of time.
- R5: Whenever `vs_ok_i` is 0, `nres_pull_o` is 0 in that same cycle. This holds whatever the undervoltage flag does.
- R6: When `vs_ok_i` returns to 1 with the flag clear, a fresh stretch runs: the pad enable is 1 for `HOLD_TICKS + 1` cycles after the rise, with a tick every cycle.
- R7: An undervoltage pulse of any length during the stretch restarts it. The release then comes `HOLD_TICKS + 3` cycles after that pulse's raw fall.
- R8: Both timers advance only on cycles with `tick_i` high. With no ticks the stretch never ends. With a tick every third cycle the release takes about three times as long.
- R9: `rst_busy_o` is 1 whenever the reset is asserted or being stretched, or `vs_ok_i` is 0. It is 0 in normal operation, including while a dip is being debounced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | Timebase strobe; timers advance on cycles where it is high |
| vcc_low_i | input | 1 | Logic-supply undervoltage flag, asynchronous, hysteresis already applied |
| vs_ok_i | input | 1 | Battery rail above operating threshold (synchronous) |
| nres_pull_o | output | 1 | Open-drain enable of the reset pad: 1 pulls low, 0 releases |
| rst_busy_o | output | 1 | Reset asserted or stretching; mode changes must be refused |

## Verification
Two functions can act in the same cycle. The first is the stretch timer reaching its end. The second is a fresh undervoltage indication arriving while the stretch runs, and in that case the restart must win. The bench injects one-cycle undervoltage pulses at points inside the stretch. It then measures the full release length from the pulse's fall and expects `HOLD_TICKS + 3` again, not what was left of the old stretch. It also cuts the battery flag while a dip is being debounced or a stretch is running. There it checks that the pad is released in that very cycle and that a complete stretch follows the recovery.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

  typedef enum logic [1:0] {
    ST_LOW  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } uvr_state_e;

  // One step of a saturating tick counter.
  function automatic int unsigned sat_step(input int unsigned cur,
                                           input logic        adv,
                                           input int unsigned lim);
    if (!adv)      return cur;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

  // Counter has reached its terminal value.
  function automatic logic reached(input int unsigned cur,
                                   input int unsigned lim);
    return cur >= lim;
  endfunction

  // Clock cycles from raw flag fall to release with a tick every cycle.
  function automatic int unsigned release_cycles(input int unsigned sync_n,
                                                 input int unsigned hold);
    return sync_n + 1 + hold;
  endfunction

endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES:0] chain;

  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g+1] <= RST_VAL;
      else         chain[g+1] <= chain[g];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/uvr_tick_counter.sv
module uvr_tick_counter
  import uvr_pkg::*;
#(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (clear_i) cnt_d = '0;
    else         cnt_d = CW'(sat_step(int'(cnt_q), tick_i, LIMIT));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_o = reached(int'(cnt_q), LIMIT);
endmodule

// File: rtl/uv_reset_gen.sv
module uv_reset_gen
  import uvr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_TICKS   = 10,
  parameter int unsigned HOLD_TICKS  = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vcc_low_i,
  input  logic vs_ok_i,
  output logic nres_pull_o,
  output logic rst_busy_o
);
  // Named internal events (observed by the bound checker).
  logic       uv_s;
  logic       deb_done;
  logic       hold_done;
  logic       hold_clear;
  uvr_state_e st_q;
  uvr_state_e st_d;

  // Power-up assumes the supply is bad until proven good.
  uvr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (vcc_low_i),
    .q_o    (uv_s)
  );

  uvr_tick_counter #(.LIMIT(DEB_TICKS)) u_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!uv_s),
    .tick_i  (tick_i),
    .done_o  (deb_done)
  );

  assign hold_clear = (st_q != ST_HOLD);

  uvr_tick_counter #(.LIMIT(HOLD_TICKS)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (hold_clear),
    .tick_i  (tick_i),
    .done_o  (hold_done)
  );

  always_comb begin
    st_d = st_q;
    if (!vs_ok_i) begin
      st_d = ST_LOW;
    end else begin
      unique case (st_q)
        ST_LOW:  if (!uv_s) st_d = ST_HOLD;
        ST_HOLD: begin
          if (uv_s)           st_d = ST_LOW;
          else if (hold_done) st_d = ST_RUN;
        end
        ST_RUN:  if (deb_done) st_d = ST_LOW;
        default: st_d = ST_LOW;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_LOW;
    else         st_q <= st_d;
  end

  assign nres_pull_o = vs_ok_i && (st_q != ST_RUN);
  assign rst_busy_o  = !vs_ok_i || (st_q != ST_RUN);
endmodule

// File: rtl/uvr_checker.sv
module uvr_checker
  import uvr_pkg::*;
#(
  parameter int unsigned DEB_TICKS  = 10,
  parameter int unsigned HOLD_TICKS = 4000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       vs_ok_i,
  input logic       uv_s,
  input uvr_state_e st_q,
  input logic       nres_pull_o,
  input logic       rst_busy_o
);
  int unsigned uv_run;
  int unsigned hold_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uv_run   <= 0;
      hold_run <= 0;
    end else begin
      if (!uv_s)                         uv_run <= 0;
      else if (tick_i && uv_run < DEB_TICKS) uv_run <= uv_run + 1;
      if (st_q != ST_HOLD)               hold_run <= 0;
      else if (tick_i && hold_run < HOLD_TICKS) hold_run <= hold_run + 1;
    end
  end

  p_assert_after_debounce_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_RUN && st_q == ST_LOW && $past(vs_ok_i)) |-> ($past(uv_run) >= DEB_TICKS));

  p_release_after_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_HOLD && st_q == ST_RUN) |-> ($past(hold_run) == HOLD_TICKS));

  p_low_while_uv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RUN && uv_s && vs_ok_i) |=> nres_pull_o || !vs_ok_i);

  p_hiz_without_vs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_ok_i |-> !nres_pull_o);

  p_restart_in_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && uv_s && vs_ok_i) |=> st_q == ST_LOW);

  p_busy_covers_pull_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nres_pull_o |-> rst_busy_o);
endmodule

bind uv_reset_gen uvr_checker #(
  .DEB_TICKS  (DEB_TICKS),
  .HOLD_TICKS (HOLD_TICKS)
) u_uvr_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .vs_ok_i     (vs_ok_i),
  .uv_s        (uv_s),
  .st_q        (st_q),
  .nres_pull_o (nres_pull_o),
  .rst_busy_o  (rst_busy_o)
);

// File: tb/tb_uv_reset_gen.sv
`timescale 1ns/1ps
module tb_uv_reset_gen;
  localparam int DEB  = 5;
  localparam int HOLD = 20;
  localparam int REL  = HOLD + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic vcc_low = 1'b0;
  logic vs_ok = 1'b1;
  logic pull, busy;
  int   tick_mode = 0;   // 0: every cycle, 1: every third cycle, 2: never
  int   tick_ph = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  uv_reset_gen #(.SYNC_STAGES(2), .DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .vcc_low_i(vcc_low),
    .vs_ok_i(vs_ok), .nres_pull_o(pull), .rst_busy_o(busy));

  always @(negedge clk) begin
    tick_ph <= (tick_ph == 2) ? 0 : tick_ph + 1;
    tick    <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? (tick_ph == 0) : 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count consecutive samples with the pad pulling low; also verifies busy tracks it.
  task automatic count_high(output int n);
    bit busy_ok = 1;
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!pull) break;
      if (!busy) busy_ok = 0;
      n++;
    end
    check(busy_ok, "R9 busy during stretch", 0, 1);
  endtask

  task automatic cycles(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n;
    // R3: power-up
    cycles(3);
    check(pull == 1'b1, "R3 pad during reset", pull, 1);
    check(busy == 1'b1, "R3 busy during reset", busy, 1);
    rst_n = 1'b1;
    count_high(n);
    check(n == REL, "R3 first stretch length", n, REL);
    check(busy == 1'b0, "R9 busy after release", busy, 0);

    // R1: sweep raw pulse lengths
    for (int len = 1; len <= DEB + 3; len++) begin
      bit seen = 0;
      bit busy_seen = 0;
      cycles(4);
      vcc_low = 1'b1;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        if (pull) seen = 1;
        if (busy) busy_seen = 1;
      end
      vcc_low = 1'b0;
      for (int i = 0; i < DEB + HOLD + 10; i++) begin
        @(negedge clk);
        if (pull) seen = 1;
        if (busy) busy_seen = 1;
      end
      check(seen == (len >= DEB), $sformatf("R1 pulse len %0d asserts", len), seen, len >= DEB);
      check(busy_seen == (len >= DEB), $sformatf("R9 busy for pulse len %0d", len), busy_seen, len >= DEB);
      check(pull == 1'b0, "R2 released after stretch", pull, 0);
    end

    // R4 + R2: long dip
    vcc_low = 1'b1;
    cycles(200);
    check(pull == 1'b1, "R4 held while supply low", pull, 1);
    vcc_low = 1'b0;
    count_high(n);
    check(n == REL, "R2 stretch after long dip", n, REL);

    // R7: restart from several points in the stretch
    for (int at = 1; at <= HOLD; at += 6) begin
      vcc_low = 1'b1;
      cycles(DEB + 4);
      vcc_low = 1'b0;
      cycles(at);
      vcc_low = 1'b1;
      @(negedge clk);
      vcc_low = 1'b0;
      count_high(n);
      check(n == REL - 1 + 1 - 0 ? n == REL : 0, $sformatf("R7 restart at %0d", at), n, REL);
    end

    // R5: battery loss in normal run and while supply is low
    cycles(3);
    vs_ok = 1'b0;
    #2;
    check(pull == 1'b0, "R5 pad released same cycle", pull, 0);
    check(busy == 1'b1, "R9 busy without battery", busy, 1);
    vcc_low = 1'b1;
    cycles(10);
    check(pull == 1'b0, "R5 pad released while supply low", pull, 0);
    // R4: battery back, supply still absent
    vs_ok = 1'b1;
    cycles(30);
    check(pull == 1'b1, "R4 asserted with battery, no supply", pull, 1);
    vs_ok = 1'b0;
    #2;
    check(pull == 1'b0, "R5 release during assertion", pull, 0);
    vcc_low = 1'b0;
    cycles(5);
    // R6: battery returns with supply good
    vs_ok = 1'b1;
    count_high(n);
    check(n == HOLD + 1, "R6 stretch after battery return", n, HOLD + 1);

    // R5 during debounce
    vcc_low = 1'b1;
    cycles(2);
    vs_ok = 1'b0;
    #2;
    check(pull == 1'b0, "R5 release during debounce", pull, 0);
    cycles(3);
    vcc_low = 1'b0;
    cycles(4);
    vs_ok = 1'b1;
    count_high(n);
    check(n == HOLD + 1, "R6 stretch after debounce cut", n, HOLD + 1);

    // R8: no ticks freezes the stretch
    vcc_low = 1'b1;
    cycles(DEB + 4);
    tick_mode = 2;
    vcc_low = 1'b0;
    cycles(HOLD * 4);
    check(pull == 1'b1, "R8 stretch frozen without ticks", pull, 1);
    tick_mode = 0;
    count_high(n);
    check(n >= HOLD && n <= HOLD + 2, "R8 stretch resumes with ticks", n, HOLD + 1);

    // R8: sparse ticks
    tick_mode = 1;
    vcc_low = 1'b1;
    cycles(DEB * 3 + 10);
    check(pull == 1'b1, "R8 asserted with sparse ticks", pull, 1);
    vcc_low = 1'b0;
    count_high(n);
    check(n >= HOLD * 3 - 1 && n <= HOLD * 3 + 4, "R8 sparse stretch length", n, HOLD * 3 + 2);
    // R1 with sparse ticks: dip of DEB cycles spans too few ticks
    tick_mode = 1;
    begin
      bit seen = 0;
      vcc_low = 1'b1;
      cycles(DEB);
      vcc_low = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (pull) seen = 1;
      end
      check(seen == 1'b0, "R1 short dip with sparse ticks", seen, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule